// File: doc/BRIEF.md
# Multichannel SPI Master Register Front-End

This block is the bus-facing register file of a multichannel SPI master. A simple 32-bit word-addressed read/write bus reaches two kinds of registers. The first kind covers the whole module: system configuration, a reset-done status, interrupt flags and their enables, a wakeup enable, a system test scratch register and a module control register. The second kind is a bank of identical per-channel groups, each holding a configuration word, a status word, a control word, a transmit data word and a receive data word. The channel groups sit at a fixed stride, so the bank grows with the channel count parameter.

The shift engines sit outside this block. Each engine reads its channel's configuration, enable and transmit word from the block's outputs. It reports back through single-cycle pulses: receive word valid, transmit word taken, end of transfer, and interrupt events. The block works out which channel chip selects are active from the module control settings and the channel enables. Software can start a soft reset that returns every register to its default value and then clears itself. A reset-done status bit shows when that sequence has finished.

Top module: `mspi_regfile`

## Requirements
- R1: After reset, system status reads 0x1, module control reads 0x4 (bit 2 = 1, slave), and every other module register reads 0. System configuration (0x10) keeps bits 0, 2 and 4:3, where 4:3 = 2 means smart idle. Wakeup enable (0x20) keeps bit 0. System test (0x24) keeps bits 7:0. Module control (0x28) keeps bits 0 (single channel), 2 (1 = slave, 0 = master) and 3 (test mode). All other bits read 0.
- R2: Writing a word with bit 1 set to 0x10 returns every register to its reset value at that clock edge. For the next cycle, system status bit 0 reads 0 and system configuration bit 1 reads 1. One cycle later both are back to 1 and 0. Bus writes are ignored while the reset is in progress.
- R3: Channel i's group starts at 0x2C + 0x14*i. Its configuration word is at +0x0, status at +0x4, control at +0x8, transmit data at +0xC and receive data at +0x10. The configuration word keeps bits CONF_W-1:0 (20:0 by default) and drives `chan_cfg`.
- R4: Control bit 0 enables the channel, which appears on `chan_on[i]`. Writing 0 to it disables the channel.
- R5: Channel status bit 0 means receive data is available, bit 1 means the transmit register is empty (1 after reset), and bit 2 means end of transfer. Bus writes to a status word have no effect.
- R6: A write to transmit data loads `chan_txd` and clears the transmit-empty and end-of-transfer flags. A pulse on `eng_tx_take[i]` sets transmit-empty, and a pulse on `eng_eot[i]` sets end-of-transfer.
- R7: A pulse on `eng_rx_vld[i]` stores `eng_rx_word` in the receive data word and sets the receive-available flag. A bus read of the receive data word clears that flag, unless a new word arrives in the same cycle.
- R8: Interrupt status (0x18) bits 2*NCH-1:0 are set by pulses on `irq_hit` and cleared by writing 1 to them. Interrupt enable (0x1C) keeps bits 2*NCH-1:0.
- R9: A read of any unmapped or misaligned offset, including offsets beyond the last channel group, returns 0. Writes to such offsets change nothing.
- R10: In slave mode no chip select is active. In master mode with module control bit 0 = 0, every enabled channel's chip select is active. In master mode with bit 0 = 1, only the lowest-numbered enabled channel's chip select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on the receive word) |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| chan_on | output | NCH | Per-channel enable |
| chan_cfg | output | NCH*CONF_W | Per-channel configuration words |
| chan_txd | output | NCH*32 | Per-channel transmit words |
| chan_cs | output | NCH | Active chip selects |
| is_master | output | 1 | Master operation selected |
| one_chan | output | 1 | Single-channel mode selected |
| eng_rx_vld | input | NCH | Receive word valid pulses |
| eng_rx_word | input | NCH*32 | Received words |
| eng_tx_take | input | NCH | Transmit word consumed pulses |
| eng_eot | input | NCH | End-of-transfer pulses |
| irq_hit | input | 2*NCH | Interrupt event pulses |

## Verification
The soft reset is checked cycle by cycle. A design that finished the reset in the same cycle would never show reset-done as 0. A design that left the request bit set would keep registers in reset. The bench drives chip select selection through the multi-channel, single-channel and slave settings with two channels enabled and a low one left off. A decoder that picked the wrong priority, or that ignored slave mode, would assert the wrong select. It also probes the edges of the address map: the offset just past the last group, misaligned offsets and the read-only status words. A decoder with loose matching would alias these offsets onto real registers, and that shows up in later readbacks.

// File: rtl/mspi_regfile.sv
module mspi_regfile #(
  parameter int NCH    = 4,
  parameter int AW     = 8,
  parameter int CONF_W = 21
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [AW-1:0]         bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [NCH-1:0]        chan_on,
  output logic [NCH*CONF_W-1:0] chan_cfg,
  output logic [NCH*32-1:0]     chan_txd,
  output logic [NCH-1:0]        chan_cs,
  output logic                  is_master,
  output logic                  one_chan,
  input  logic [NCH-1:0]        eng_rx_vld,
  input  logic [NCH*32-1:0]     eng_rx_word,
  input  logic [NCH-1:0]        eng_tx_take,
  input  logic [NCH-1:0]        eng_eot,
  input  logic [2*NCH-1:0]      irq_hit
);
  localparam int CH_BASE = 'h2C;
  localparam int STRIDE  = 'h14;
  localparam int IW      = 2*NCH;

  logic          busy;
  logic [4:0]    sysc;
  logic [IW-1:0] irq_st, irq_en;
  logic          wake;
  logic [7:0]    syst;
  logic [2:0]    modc;

  logic [CONF_W-1:0] cfg [NCH];
  logic [31:0]       txq [NCH];
  logic [31:0]       rxq [NCH];
  logic [NCH-1:0]    en, rxa, txe, eot;
  logic [4:0]        hsel [NCH];

  wire wr_ok = bus_wr && !busy;
  wire hit_sc = bus_addr == AW'('h10);
  wire hit_ss = bus_addr == AW'('h14);
  wire hit_is = bus_addr == AW'('h18);
  wire hit_ie = bus_addr == AW'('h1C);
  wire hit_wk = bus_addr == AW'('h20);
  wire hit_st = bus_addr == AW'('h24);
  wire hit_mc = bus_addr == AW'('h28);
  wire srst   = wr_ok && hit_sc && bus_wdata[1];

  assign is_master = !modc[1];
  assign one_chan  = modc[0];
  assign chan_on   = en;

  always_ff @(posedge clk) begin
    busy <= rst_n && srst;
    if (!rst_n || srst) begin
      sysc <= '0; irq_st <= '0; irq_en <= '0; wake <= 1'b0; syst <= '0; modc <= 3'b010;
    end else begin
      if (wr_ok && hit_sc) sysc <= bus_wdata[4:0] & 5'b11101;
      if (wr_ok && hit_ie) irq_en <= bus_wdata[IW-1:0];
      if (wr_ok && hit_wk) wake <= bus_wdata[0];
      if (wr_ok && hit_st) syst <= bus_wdata[7:0];
      if (wr_ok && hit_mc) modc <= {bus_wdata[3], bus_wdata[2], bus_wdata[0]};
      irq_st <= (irq_st & ~((wr_ok && hit_is) ? bus_wdata[IW-1:0] : '0)) | irq_hit;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    for (genvar k = 0; k < 5; k++) begin : g_hit
      assign hsel[i][k] = bus_addr == AW'(CH_BASE + STRIDE*i + 4*k);
    end
    assign chan_cfg[i*CONF_W +: CONF_W] = cfg[i];
    assign chan_txd[i*32 +: 32]         = txq[i];

    always_ff @(posedge clk) begin
      if (!rst_n || srst) begin
        cfg[i] <= '0; en[i] <= 1'b0; txq[i] <= '0; rxq[i] <= '0;
        rxa[i] <= 1'b0; txe[i] <= 1'b1; eot[i] <= 1'b0;
      end else begin
        if (wr_ok && hsel[i][0]) cfg[i] <= bus_wdata[CONF_W-1:0];
        if (wr_ok && hsel[i][2]) en[i] <= bus_wdata[0];
        if (wr_ok && hsel[i][3]) begin
          txq[i] <= bus_wdata; txe[i] <= 1'b0; eot[i] <= 1'b0;
        end else begin
          if (eng_tx_take[i]) txe[i] <= 1'b1;
          if (eng_eot[i])     eot[i] <= 1'b1;
        end
        if (eng_rx_vld[i]) begin
          rxq[i] <= eng_rx_word[i*32 +: 32]; rxa[i] <= 1'b1;
        end else if (bus_rd && hsel[i][4]) begin
          rxa[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_sc) bus_rdata = {27'b0, sysc[4:2], busy, sysc[0]};
    if (hit_ss) bus_rdata = {31'b0, !busy};
    if (hit_is) bus_rdata = 32'(irq_st);
    if (hit_ie) bus_rdata = 32'(irq_en);
    if (hit_wk) bus_rdata = {31'b0, wake};
    if (hit_st) bus_rdata = {24'b0, syst};
    if (hit_mc) bus_rdata = {28'b0, modc[2], modc[1], 1'b0, modc[0]};
    for (int i = 0; i < NCH; i++) begin
      if (hsel[i][0]) bus_rdata = 32'(cfg[i]);
      if (hsel[i][1]) bus_rdata = {29'b0, eot[i], txe[i], rxa[i]};
      if (hsel[i][2]) bus_rdata = {31'b0, en[i]};
      if (hsel[i][3]) bus_rdata = txq[i];
      if (hsel[i][4]) bus_rdata = rxq[i];
    end
  end

  always_comb begin
    logic taken;
    taken   = 1'b0;
    chan_cs = '0;
    for (int i = 0; i < NCH; i++) begin
      if (is_master && en[i] && !(one_chan && taken)) begin
        chan_cs[i] = 1'b1;
        taken      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mspi_regfile_chk.sv
module mspi_regfile_chk #(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           srst,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [AW-1:0]  bus_addr,
  input logic [NCH-1:0] chan_on,
  input logic [NCH-1:0] chan_cs,
  input logic           is_master,
  input logic           one_chan,
  input logic [NCH-1:0] txe,
  input logic [NCH-1:0] rxa,
  input logic [NCH-1:0] eng_rx_vld
);
  AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !busy); // R2
  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n) srst |=> (busy && chan_on == '0 && !is_master)); // R2
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) one_chan |-> $onehot0(chan_cs)); // R10
  AST_CS_SUBSET: assert property (@(posedge clk) disable iff (!rst_n) (chan_cs & ~chan_on) == '0); // R10
  AST_CS_SLAVE: assert property (@(posedge clk) disable iff (!rst_n) !is_master |-> chan_cs == '0); // R10

  for (genvar i = 0; i < NCH; i++) begin : g_a
    localparam int TXO = 'h2C + 'h14*i + 'hC;
    localparam int RXO = 'h2C + 'h14*i + 'h10;
    AST_TX_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !busy && bus_addr == AW'(TXO)) |=> !txe[i]); // R6
    AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == AW'(RXO) && !eng_rx_vld[i]) |=> !rxa[i]); // R7
    AST_RX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_vld[i] && !srst) |=> rxa[i]); // R7
  end
endmodule

bind mspi_regfile mspi_regfile_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .srst(srst), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .chan_on(chan_on), .chan_cs(chan_cs),
  .is_master(is_master), .one_chan(one_chan), .txe(txe), .rxa(rxa),
  .eng_rx_vld(eng_rx_vld)
);

// File: tb/mspi_regfile_tb.sv
`timescale 1ns/1ps
module mspi_regfile_tb;
  localparam int NCH = 4;
  localparam int CW  = 21;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] chan_on, chan_cs;
  logic [NCH*CW-1:0] chan_cfg;
  logic [NCH*32-1:0] chan_txd;
  logic is_master, one_chan;
  logic [NCH-1:0] eng_rx_vld = '0, eng_tx_take = '0, eng_eot = '0;
  logic [NCH*32-1:0] eng_rx_word = '0;
  logic [2*NCH-1:0] irq_hit = '0;
  int vecs = 0, bad = 0;

  always #4 clk = ~clk;

  mspi_regfile u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  function automatic logic [7:0] cho(input int ch, input int k);
    return 8'('h2C + 'h14*ch + 4*k);
  endfunction

  task automatic t_reset();
    rdchk("R1 sysstatus", 8'h14, 32'h1);
    rdchk("R1 modctrl", 8'h28, 32'h4);
    rdchk("R1 sysconfig", 8'h10, 32'h0);
    rdchk("R5 ch0 status", cho(0,1), 32'h2);
    rdchk("R4 ch3 ctrl", cho(3,2), 32'h0);
    settle(); chk("R4 chan_on", 32'(chan_on), 32'h0);
  endtask

  task automatic t_modregs();
    wr(8'h10, 32'h15); rdchk("R1 sysconfig smart idle", 8'h10, 32'h15);
    wr(8'h10, 32'hFFFF_FFFD); rdchk("R1 sysconfig mask", 8'h10, 32'h1D);
    wr(8'h20, 32'hFFFF_FFFF); rdchk("R1 wakeup", 8'h20, 32'h1);
    wr(8'h24, 32'h1A5); rdchk("R1 systest", 8'h24, 32'hA5);
    wr(8'h28, 32'hFFFF_FFFF); rdchk("R1 modctrl mask", 8'h28, 32'hD);
    wr(8'h28, 32'h4);
  endtask

  task automatic t_chan();
    for (int i = 0; i < NCH; i++) begin
      wr(cho(i,0), 32'hFFFF_FFFF);
      rdchk("R3 conf readback", cho(i,0), 32'h001F_FFFF);
      wr(cho(i,2), 32'h1);
      settle();
      chk("R4 chan_on set", 32'(chan_on[i]), 32'h1);
      chk("R3 chan_cfg", 32'(chan_cfg[i*CW +: CW]), 32'h001F_FFFF);
      wr(cho(i,2), 32'h0);
      wr(cho(i,0), 32'h0);
    end
    settle(); chk("R4 chan_on cleared", 32'(chan_on), 32'h0);
  endtask

  task automatic t_tx();
    wr(cho(2,3), 32'h1234_5678);
    settle(); chk("R6 chan_txd", chan_txd[64 +: 32], 32'h1234_5678);
    rdchk("R6 tx readback", cho(2,3), 32'h1234_5678);
    rdchk("R6 status after write", cho(2,1), 32'h0);
    @(negedge clk); eng_tx_take[2] = 1'b1; @(posedge clk); #1 eng_tx_take[2] = 1'b0;
    rdchk("R6 tx taken", cho(2,1), 32'h2);
    @(negedge clk); eng_eot[2] = 1'b1; @(posedge clk); #1 eng_eot[2] = 1'b0;
    rdchk("R5 eot", cho(2,1), 32'h6);
    wr(cho(2,1), 32'h0);
    rdchk("R5 status read-only", cho(2,1), 32'h6);
  endtask

  task automatic t_rx();
    @(negedge clk); eng_rx_vld[1] = 1'b1; eng_rx_word[32 +: 32] = 32'hCAFE_F00D;
    @(posedge clk); #1 eng_rx_vld[1] = 1'b0;
    rdchk("R7 rx available", cho(1,1), 32'h3);
    rdchk("R7 rx word", cho(1,4), 32'hCAFE_F00D);
    rdchk("R7 rx cleared by read", cho(1,1), 32'h2);
  endtask

  task automatic t_irq();
    @(negedge clk); irq_hit = 8'h05; @(posedge clk); #1 irq_hit = '0;
    rdchk("R8 irq set", 8'h18, 32'h5);
    wr(8'h18, 32'h1);
    rdchk("R8 irq w1c", 8'h18, 32'h4);
    wr(8'h1C, 32'hFFFF);
    rdchk("R8 irq enable", 8'h1C, 32'hFF);
  endtask

  task automatic t_unmapped();
    rdchk("R9 offset 0", 8'h00, 32'h0);
    rdchk("R9 past last group", 8'h7C, 32'h0);
    rdchk("R9 misaligned", 8'h2E, 32'h0);
    wr(8'h7C, 32'hFFFF_FFFF);
    wr(8'h2D, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0);
    rdchk("R9 ch0 conf untouched", cho(0,0), 32'h0);
    rdchk("R9 ch3 rx untouched", cho(3,4), 32'h0);
    rdchk("R9 sysstatus untouched", 8'h14, 32'h1);
    settle(); chk("R9 chan_on untouched", 32'(chan_on), 32'h0);
  endtask

  task automatic t_cs();
    wr(cho(1,2), 32'h1); wr(cho(3,2), 32'h1);
    wr(8'h28, 32'h0);
    settle(); chk("R10 multi master", 32'(chan_cs), 32'hA);
    wr(8'h28, 32'h1);
    settle(); chk("R10 single lowest", 32'(chan_cs), 32'h2);
    wr(8'h28, 32'h5);
    settle(); chk("R10 slave none", 32'(chan_cs), 32'h0);
    wr(8'h28, 32'h1);
  endtask

  task automatic t_srst();
    wr(8'h10, 32'h2);
    rdchk("R2 reset in progress", 8'h14, 32'h0);
    rdchk("R2 reset done", 8'h14, 32'h1);
    rdchk("R2 request self-cleared", 8'h10, 32'h0);
    rdchk("R2 modctrl default", 8'h28, 32'h4);
    rdchk("R2 ch1 status default", cho(1,1), 32'h2);
    rdchk("R2 ch2 tx default", cho(2,3), 32'h0);
    settle(); chk("R2 chan_on default", 32'(chan_on), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_modregs();
    t_chan();
    t_tx();
    t_rx();
    t_irq();
    t_unmapped();
    t_cs();
    t_srst();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule